// File: doc/BRIEF.md
# Stream Instruction Controller

A multicycle sequencer that steps through a program of 8-bit instruction words and turns each one into control strobes for an arithmetic unit and a register file. It holds a program counter, an address register that drives the instruction memory port, and an instruction register. A phase machine walks every instruction through two fetch cycles, one decode cycle, an execute stretch whose length depends on the operation, and a write-back cycle.

The instruction memory sits outside the block. The address register drives `imem_addr_o`, and the memory must return the addressed word on `imem_data_i` within the same cycle. Decoded fields are registered at the end of decode and held until the next decode. Downstream logic starts an operation on `exec_start_o` and commits its result to the register named by `dst_o` on `wb_en_o`.

Top module: `stream_ctrl`

## Requirements
- R1: While `rst_ni` is low, the program counter and address register are 0, `op_o`, `dst_o`, `src_o` and `imem_addr_o` read 0, and both strobes are low. After release, the first fetch reads address 0.
- R2: Instruction word layout: bits [7:6] select the destination, bits [5:4] select the source, and bits [3:0] carry the opcode. After the decode cycle, `dst_o`, `src_o` and `op_o` show these fields, and they hold until the next decode.
- R3: Fetch takes two cycles. The first copies the program counter into the address register. In the second, `imem_addr_o` shows that address and the returned word is loaded into the instruction register.
- R4: The program counter advances by exactly one for each instruction, at the cycle the instruction register is loaded. It wraps from 255 to 0.
- R5: Opcode codes are NOP=0, ADD=1, MUL=2 and SQRT=3. Any other code is reported on `op_o` as 0 and handled as NOP.
- R6: `exec_start_o` is a single-cycle pulse on the first execute cycle of ADD, MUL and SQRT. It never fires for NOP.
- R7: `wb_en_o` is a single-cycle pulse in the cycle right after the last execute cycle, while `dst_o` holds the destination of that instruction. NOP produces no write-back.
- R8: An instruction occupies 3 cycles for NOP, 5 for ADD, and 6 for MUL and SQRT. Execute lasts 0, 1 and 2 cycles respectively. The next fetch begins right after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| imem_addr_o | output | AW | Instruction memory address, driven by the address register |
| imem_data_i | input | 8 | Instruction word at `imem_addr_o` |
| op_o | output | 4 | Normalised opcode of the current instruction |
| dst_o | output | 2 | Destination register select |
| src_o | output | 2 | Source register select |
| exec_start_o | output | 1 | Start strobe to the arithmetic unit |
| wb_en_o | output | 1 | Write-back strobe to the register file |

## Verification
The hardest situation to reach is the program counter wrapping from 255 to 0 in the middle of a mix of instruction lengths, with every unused opcode appearing along the way. The bench supplies a memory whose word at address a is (37·a + 11) mod 256. The low nibble of that word steps through all sixteen codes, and the field pairs vary from address to address. Running 300 instructions therefore carries the counter across the wrap. A second reset asserted in the middle of an instruction then shows that the schedule restarts cleanly from address 0.

// File: rtl/stream_ctrl_pkg.sv
package stream_ctrl_pkg;
  localparam int unsigned IW  = 8;
  localparam int unsigned SW  = 2;
  localparam int unsigned OPW = IW - 2 * SW;
  localparam int unsigned LW  = 2;

  typedef enum logic [OPW-1:0] {
    OP_NOP  = 4'h0,
    OP_ADD  = 4'h1,
    OP_MUL  = 4'h2,
    OP_SQRT = 4'h3
  } op_e;

  typedef enum logic [2:0] {
    PH_FADDR,
    PH_FREAD,
    PH_DEC,
    PH_EXEC,
    PH_WB
  } phase_e;

  typedef struct packed {
    logic [SW-1:0]  dst;
    logic [SW-1:0]  src;
    logic [OPW-1:0] op;
  } instr_t;

  function automatic op_e op_norm(logic [OPW-1:0] raw);
    case (raw)
      4'h1:    return OP_ADD;
      4'h2:    return OP_MUL;
      4'h3:    return OP_SQRT;
      default: return OP_NOP;
    endcase
  endfunction

  function automatic logic [LW-1:0] exec_cycles(op_e op);
    case (op)
      OP_ADD:          return 2'd1;
      OP_MUL, OP_SQRT: return 2'd2;
      default:         return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/stream_pc_unit.sv
module stream_pc_unit #(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_ar_i,
  input  logic          inc_pc_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] ar_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o <= '0;
      ar_o <= '0;
    end else begin
      if (load_ar_i) ar_o <= pc_o;
      if (inc_pc_i)  pc_o <= pc_o + 1'b1; // natural wrap
    end
  end

  a_r4_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_o != $past(pc_o)) |-> (pc_o == $past(pc_o) + 1'b1));

  a_r4_pc_only_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_pc_i |=> $stable(pc_o));
endmodule

// File: rtl/stream_decoder.sv
module stream_decoder
  import stream_ctrl_pkg::*;
(
  input  logic [IW-1:0]  ir_i,
  output op_e            op_o,
  output logic [SW-1:0]  dst_o,
  output logic [SW-1:0]  src_o,
  output logic [LW-1:0]  len_o
);
  instr_t f;
  always_comb begin
    f     = instr_t'(ir_i);
    op_o  = op_norm(f.op);
    dst_o = f.dst;
    src_o = f.src;
    len_o = exec_cycles(op_o);
  end
endmodule

// File: rtl/stream_phase_fsm.sv
module stream_phase_fsm
  import stream_ctrl_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [LW-1:0] len_i,
  output logic          load_ar_o,
  output logic          load_ir_o,
  output logic          dec_o,
  output logic          exec_start_o,
  output logic          wb_en_o
);
  phase_e        ph_q, ph_d;
  logic [LW-1:0] cnt_q, len_q;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_FADDR: ph_d = PH_FREAD;
      PH_FREAD: ph_d = PH_DEC;
      PH_DEC:   ph_d = (len_i == '0) ? PH_FADDR : PH_EXEC;
      PH_EXEC:  ph_d = (cnt_q == len_q - 1'b1) ? PH_WB : PH_EXEC;
      PH_WB:    ph_d = PH_FADDR;
      default:  ph_d = PH_FADDR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_FADDR;
      cnt_q <= '0;
      len_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (ph_q == PH_DEC) begin
        len_q <= len_i;
        cnt_q <= '0;
      end else if (ph_q == PH_EXEC) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign load_ar_o    = (ph_q == PH_FADDR);
  assign load_ir_o    = (ph_q == PH_FREAD);
  assign dec_o        = (ph_q == PH_DEC);
  assign exec_start_o = (ph_q == PH_EXEC) && (cnt_q == '0);
  assign wb_en_o      = (ph_q == PH_WB);

  a_r8_wb_then_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_WB) |=> (ph_q == PH_FADDR));

  a_r3_fetch_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_FADDR) |=> (ph_q == PH_FREAD));

  a_r8_exec_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_EXEC) |-> (cnt_q < len_q));
endmodule

// File: rtl/stream_ctrl.sv
module stream_ctrl
  import stream_ctrl_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [AW-1:0] imem_addr_o,
  input  logic [IW-1:0] imem_data_i,
  output logic [OPW-1:0] op_o,
  output logic [SW-1:0] dst_o,
  output logic [SW-1:0] src_o,
  output logic          exec_start_o,
  output logic          wb_en_o
);
  logic          load_ar, load_ir, dec;
  logic [AW-1:0] pc;
  logic [IW-1:0] ir_q;
  op_e           d_op;
  logic [SW-1:0] d_dst, d_src;
  logic [LW-1:0] d_len;

  stream_pc_unit #(.AW(AW)) u_pc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_ar_i (load_ar),
    .inc_pc_i  (load_ir),
    .pc_o      (pc),
    .ar_o      (imem_addr_o)
  );

  stream_decoder u_dec (
    .ir_i  (ir_q),
    .op_o  (d_op),
    .dst_o (d_dst),
    .src_o (d_src),
    .len_o (d_len)
  );

  stream_phase_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .len_i        (d_len),
    .load_ar_o    (load_ar),
    .load_ir_o    (load_ir),
    .dec_o        (dec),
    .exec_start_o (exec_start_o),
    .wb_en_o      (wb_en_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_q  <= '0;
      op_o  <= '0;
      dst_o <= '0;
      src_o <= '0;
    end else begin
      if (load_ir) ir_q <= imem_data_i;
      if (dec) begin
        op_o  <= d_op;
        dst_o <= d_dst;
        src_o <= d_src;
      end
    end
  end

  a_r6_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_start_o |=> !exec_start_o);

  a_r7_wb_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |=> !wb_en_o);

  a_r7_wb_apart_from_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_start_o |-> !wb_en_o);

  a_r5_nop_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec && d_op == OP_NOP) |=> !exec_start_o);

  a_r2_fields_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec |=> ($stable(op_o) && $stable(dst_o) && $stable(src_o)));
endmodule

// File: tb/tb_stream_ctrl.sv
module tb_stream_ctrl;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] imem_addr;
  logic [7:0] imem_data;
  logic [3:0] op;
  logic [1:0] dst, src;
  logic       exec_start, wb_en;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int t_s = 0;
  int idx = 0;
  bit run = 1'b0;
  bit done = 1'b0;

  logic [7:0] w;
  logic [3:0] eop;
  int len, endc;
  bit exp_s, exp_w;

  always #10 clk = ~clk;

  function automatic logic [7:0] rom_word(logic [7:0] a);
    return a * 8'd37 + 8'd11;
  endfunction

  assign imem_data = rom_word(imem_addr);

  stream_ctrl #(.AW(8)) dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .imem_addr_o  (imem_addr),
    .imem_data_i  (imem_data),
    .op_o         (op),
    .dst_o        (dst),
    .src_o        (src),
    .exec_start_o (exec_start),
    .wb_en_o      (wb_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cyc <= 0;
    else         cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (run && rst_ni) begin
      w   = rom_word(8'(idx % 256));
      eop = (w[3:0] <= 4'd3) ? w[3:0] : 4'd0;
      len = (eop == 4'd0) ? 0 : (eop == 4'd1) ? 1 : 2;
      if (cyc == t_s + 1)
        chk(imem_addr == 8'(idx % 256), "R3 R4 R8 fetch address", imem_addr, idx % 256);
      if (cyc == t_s + 3) begin
        chk(op == eop, "R5 opcode", op, eop);
        chk(dst == w[7:6], "R2 dst field", dst, w[7:6]);
        chk(src == w[5:4], "R2 src field", src, w[5:4]);
      end
      exp_s = (len > 0) && (cyc == t_s + 3);
      exp_w = (len > 0) && (cyc == t_s + 3 + len);
      chk(exec_start == exp_s, "R6 exec_start", exec_start, exp_s);
      chk(wb_en == exp_w, "R7 wb_en", wb_en, exp_w);
      if (exp_w) chk(dst == w[7:6], "R7 wb destination", dst, w[7:6]);
      endc = (len == 0) ? t_s + 2 : t_s + 3 + len;
      if (cyc == endc) begin
        t_s = endc + 1;
        idx++;
      end
    end
  end

  task automatic reset_checks();
    @(negedge clk);
    chk(imem_addr == 8'd0, "R1 addr in reset", imem_addr, 0);
    chk(op == 4'd0, "R1 op in reset", op, 0);
    chk(dst == 2'd0 && src == 2'd0, "R1 selects in reset", {dst, src}, 0);
    chk(!exec_start && !wb_en, "R1 strobes in reset", {exec_start, wb_en}, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    reset_checks();
    t_s = 0; idx = 0; run = 1'b1;
    rst_ni = 1'b1;
    while (idx < 300) @(negedge clk);
    // reset in the middle of an instruction
    repeat (4) @(negedge clk);
    run = 1'b0;
    rst_ni = 1'b0;
    reset_checks();
    @(negedge clk);
    t_s = 0; idx = 0; run = 1'b1;
    rst_ni = 1'b1;
    while (idx < 40) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", idx, 300);
    finish_run();
  end
endmodule